// File: doc/BRIEF.md
# Byte-Wide ROM Burst Read Sequencer

This block answers a four-beat processor burst read from a ROM whose data path is one byte wide. Each 64-bit beat is assembled from eight consecutive byte reads. The sequencer drives the ROM address and output enable and shifts each returned byte into the beat register. At the end of each beat's overhead window it presents the finished beat with a one-clock valid strobe.

The cycle cost is fixed by two configuration inputs, both captured when a request is accepted. The first is the byte access latency `cfg_lat`: every byte read holds the output enable for `cfg_lat + 2` clocks. The second is the turnaround setting `cfg_wait`. After the last ROM access the block keeps `busy` high for `2 + (cfg_wait - 1)` further clocks. This gives the ROM time to release the bus before any other memory access can begin. A `cfg_wait` of zero is treated as one. A one-clock `done` pulse ends the operation.

The state machine has six states. IDLE leaves to BYTE on an accepted start. BYTE loops to itself for the next byte, and after the eighth byte moves to BEAT_OVH. BEAT_OVH returns to BYTE for the next beat, or goes to TAIL after the fourth beat. TAIL leads to TURN, TURN to DONE, and DONE back to IDLE.

Top module: `rom_burst_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rom_oe` and `beat_valid` are all low.
- R2: A `start` sampled high in IDLE is accepted, and `busy` is high in the following clock. `cfg_lat`, `cfg_wait` and `req_addr` are captured at that edge.
- R3: Each byte read holds `rom_oe` high for exactly `cfg_lat + 2` clocks, and `rom_addr` stays constant over that read.
- R4: Byte addresses start at `req_addr` with its five low bits cleared and increase by one per byte read, 32 reads in total.
- R5: Bytes are packed big-endian: the first byte of a beat lands in bits 63:56 and the eighth in bits 7:0.
- R6: A beat spans eight byte reads plus 3 clocks with `rom_oe` low. `beat_valid` is high for one clock, in the last of those 3 clocks, with the finished beat on `beat_data`.
- R7: The burst phase lasts four beats plus 5 further clocks.
- R8: The turnaround that follows lasts `cfg_wait + 1` clocks (a setting of 0 counts as 1). During it `rom_oe` is low and `busy` stays high.
- R9: `done` is high for one clock right after the turnaround ends, with `busy` low in that clock and afterwards.
- R10: `start` has no effect while `busy` is high, including during the turnaround.
- R11: With `cfg_lat` = 4 and `cfg_wait` = 3, `busy` is high for exactly 213 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request strobe |
| req_addr | input | ADDR_W | Burst byte address |
| cfg_lat | input | LAT_W | Byte access latency setting |
| cfg_wait | input | TMR_W | Turnaround wait setting |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_oe | output | 1 | ROM output enable |
| rom_data | input | 8 | ROM data byte |
| beat_data | output | 64 | Assembled beat |
| beat_valid | output | 1 | Beat valid strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete pulse |

## Verification
The bench predicts the expected state of the output enable, the address, the valid strobe and `busy` for every clock of each burst. An off-by-one in any overhead counter therefore shows up as a strobe or a `done` in the wrong clock. A design that drops the address alignment reads from the unaligned start and returns wrong beats. Reversed packing shows up as byte-swapped beats. A design that accepts `start` during the turnaround would raise `busy` again after `done`, and the bench looks for that. The minimum latency and the zero wait setting are exercised to expose a counter that underflows or skips its shortest window.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_BYTE     = 3'd1,
        S_BEAT_OVH = 3'd2,
        S_TAIL     = 3'd3,
        S_TURN     = 3'd4,
        S_DONE     = 3'd5
    } seq_state_t;
endpackage

// File: rtl/rom_seq_timer.sv
module rom_seq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/rom_seq_packer.sv
module rom_seq_packer #(
    parameter int BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic [7:0]         din,
    output logic [BYTES*8-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (shift_en)
            dout <= {dout[BYTES*8-9:0], din};
    end
endmodule

// File: rtl/rom_burst_seq.sv
module rom_burst_seq
    import rom_seq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LAT_W    = 4,
    parameter int TMR_W    = 3,
    parameter int BEATS    = 4,
    parameter int BEAT_OVH = 3,
    parameter int TAIL_OVH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LAT_W-1:0]  cfg_lat,
    input  logic [TMR_W-1:0]  cfg_wait,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_oe,
    input  logic [7:0]        rom_data,
    output logic [63:0]       beat_data,
    output logic              beat_valid,
    output logic              busy,
    output logic              done
);
    localparam int BYTES   = 8;
    localparam int BYTE_W  = $clog2(BYTES);
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int ALIGN_W = $clog2(BYTES * BEATS);
    localparam int MAXW    = (LAT_W > TMR_W) ? LAT_W : TMR_W;
    localparam int CNT_W   = ((MAXW > 3) ? MAXW : 3) + 1;

    seq_state_t        state_q, state_d;
    logic [BYTE_W-1:0] byte_q, byte_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [LAT_W-1:0]  lat_q, lat_d;
    logic [TMR_W-1:0]  wait_q, wait_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              pack_en;
    logic [CNT_W-1:0]  byte_len_m1;

    assign byte_len_m1 = CNT_W'(lat_q) + CNT_W'(1);

    rom_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rom_seq_packer #(.BYTES(BYTES)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pack_en),
        .din      (rom_data),
        .dout     (beat_data)
    );

    always_comb begin
        state_d  = state_q;
        byte_d   = byte_q;
        beat_d   = beat_q;
        base_d   = base_q;
        lat_d    = lat_q;
        wait_d   = wait_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    base_d   = {req_addr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                    lat_d    = cfg_lat;
                    wait_d   = (cfg_wait == '0) ? TMR_W'(1) : cfg_wait;
                    byte_d   = '0;
                    beat_d   = '0;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(cfg_lat) + CNT_W'(1);
                    state_d  = S_BYTE;
                end
            end
            S_BYTE: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (byte_q == BYTE_W'(BYTES - 1)) begin
                        tmr_val = CNT_W'(BEAT_OVH - 1);
                        state_d = S_BEAT_OVH;
                    end else begin
                        byte_d  = byte_q + 1'b1;
                        tmr_val = byte_len_m1;
                    end
                end
            end
            S_BEAT_OVH: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (beat_q == BEAT_W'(BEATS - 1)) begin
                        tmr_val = CNT_W'(TAIL_OVH - 1);
                        state_d = S_TAIL;
                    end else begin
                        beat_d  = beat_q + 1'b1;
                        byte_d  = '0;
                        tmr_val = byte_len_m1;
                        state_d = S_BYTE;
                    end
                end
            end
            S_TAIL: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(wait_q);
                    state_d  = S_TURN;
                end
            end
            S_TURN: begin
                if (tmr_zero)
                    state_d = S_DONE;
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            byte_q  <= '0;
            beat_q  <= '0;
            base_q  <= '0;
            lat_q   <= '0;
            wait_q  <= TMR_W'(1);
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            beat_q  <= beat_d;
            base_q  <= base_d;
            lat_q   <= lat_d;
            wait_q  <= wait_d;
        end
    end

    always_comb begin
        rom_oe     = (state_q == S_BYTE);
        pack_en    = (state_q == S_BYTE) && tmr_zero;
        beat_valid = (state_q == S_BEAT_OVH) && tmr_zero && rst_n;
        busy       = (state_q != S_IDLE) && (state_q != S_DONE);
        done       = (state_q == S_DONE);
        rom_addr   = base_q + ADDR_W'({beat_q, byte_q});
    end

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy); // R2
    AST_OE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_oe |-> busy); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_oe && !tmr_zero) |=> $stable(rom_addr)); // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> !beat_valid); // R6
    AST_TURN_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TURN) |-> (!rom_oe && busy)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(base_q)); // R10
endmodule

// File: tb/rom_burst_seq_test.sv
module rom_burst_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  cfg_lat = '0;
    logic [2:0]  cfg_wait = '0;
    logic [31:0] rom_addr;
    logic        rom_oe;
    logic [7:0]  rom_data;
    logic [63:0] beat_data;
    logic        beat_valid;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom_fn(input logic [31:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5;
    endfunction

    assign rom_data = rom_fn(rom_addr);

    rom_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
        .cfg_lat(cfg_lat), .cfg_wait(cfg_wait), .rom_addr(rom_addr),
        .rom_oe(rom_oe), .rom_data(rom_data), .beat_data(beat_data),
        .beat_valid(beat_valid), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(busy == 0, "R1", "busy after reset", busy, 0);
        check(done == 0, "R1", "done after reset", done, 0);
        check(rom_oe == 0, "R1", "rom_oe after reset", rom_oe, 0);
        check(beat_valid == 0, "R1", "beat_valid after reset", beat_valid, 0);
    endtask

    // Runs one burst and predicts every cycle; inj > 0 pulses start in that busy cycle.
    task automatic run_burst(input logic [31:0] addr, input int lat, input int wt,
                             input int inj, input int exp_busy);
        int weff, len, per, bphase, tot;
        int oe_err, addr_err, val_err, busy_err, n_busy, n_valid;
        logic [31:0] base;
        weff = (wt == 0) ? 1 : wt;
        len  = lat + 2;
        per  = 8 * len + 3;
        bphase = 4 * per + 5;
        tot  = bphase + weff + 1;
        base = {addr[31:5], 5'b0};
        oe_err = 0; addr_err = 0; val_err = 0; busy_err = 0; n_busy = 0; n_valid = 0;
        req_addr = addr; cfg_lat = 4'(lat); cfg_wait = 3'(wt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        req_addr = 32'hFFFF_FFE0;
        cfg_lat = 4'd9; cfg_wait = 3'd6;
        for (int c = 1; c <= tot + 1; c++) begin
            bit exp_oe, exp_val;
            int pos, bt, r;
            logic [31:0] exp_a;
            pos = c - 1;
            exp_oe = 0; exp_val = 0; exp_a = '0; bt = 0;
            if (pos < 4 * per) begin
                bt = pos / per;
                r  = pos % per;
                if (r < 8 * len) begin
                    exp_oe = 1;
                    exp_a  = base + 32'(bt * 8 + r / len);
                end
                exp_val = (r == per - 1);
            end
            if (busy) n_busy++;
            if (c <= tot && !busy) busy_err++;
            if (rom_oe != exp_oe) begin
                if (oe_err == 0) check(0, "R3", $sformatf("rom_oe cycle %0d", c), rom_oe, exp_oe);
                oe_err++;
            end else if (exp_oe && rom_addr != exp_a) begin
                if (addr_err == 0) check(0, "R4", $sformatf("rom_addr cycle %0d", c), rom_addr, exp_a);
                addr_err++;
            end
            if (beat_valid != exp_val) begin
                if (val_err == 0) check(0, "R6", $sformatf("beat_valid cycle %0d", c), beat_valid, exp_val);
                val_err++;
            end
            if (exp_val && beat_valid) begin
                logic [63:0] eb;
                eb = '0;
                for (int k = 0; k < 8; k++) eb = {eb[55:0], rom_fn(base + 32'(bt * 8 + k))};
                check(beat_data == eb, "R5", $sformatf("beat %0d data", bt), beat_data, eb);
                n_valid++;
            end
            if (c > bphase && c <= tot && rom_oe)
                check(0, "R8", "rom_oe in turnaround", rom_oe, 0);
            if (c == tot + 1) begin
                check(done == 1, "R9", "done after turnaround", done, 1);
                check(busy == 0, "R9", "busy with done", busy, 0);
            end else if (done) begin
                check(0, "R9", $sformatf("early done cycle %0d", c), done, 0);
            end
            if (inj > 0 && c == inj) begin
                start = 1'b1;
                req_addr = addr + 32'h100;
            end else begin
                start = 1'b0;
            end
            if (c <= tot) @(negedge clk);
        end
        start = 1'b0;
        check(oe_err == 0, "R3", "oe window count", oe_err, 0);
        check(addr_err == 0, "R4", "address sequence", addr_err, 0);
        check(val_err == 0 && n_valid == 4, "R6", "valid strobes", n_valid, 4);
        check(busy_err == 0 && n_busy == tot, "R8", "busy span", n_busy, tot);
        check(n_busy == exp_busy, "R7", "busy length vs requirement", n_busy, exp_busy);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!busy && !done && !rom_oe, "R10", "idle after done", {busy, done, rom_oe}, 0);
        end
    endtask

    task automatic test_example();
        run_burst(32'h0000_1000, 4, 3, 0, 213); // R11
    endtask

    task automatic test_unaligned_min();
        run_burst(32'h0000_2A37, 0, 1, 0, 4 * 19 + 5 + 2); // R4 R8 minimum
    endtask

    task automatic test_zero_wait();
        run_burst(32'h0001_0040, 2, 0, 0, 4 * 35 + 5 + 2); // R8 zero treated as one
    endtask

    task automatic test_start_mid_burst();
        run_burst(32'h0000_0300, 1, 5, 50, 4 * 27 + 5 + 6); // R10
    endtask

    task automatic test_start_in_turn();
        int t;
        t = 4 * (8 * 5 + 3) + 5 + 7;
        run_burst(32'h0000_0500, 3, 6, t, t); // R10 last turnaround cycle
    endtask

    task automatic test_accept();
        @(negedge clk);
        req_addr = 32'h40; cfg_lat = 4'd0; cfg_wait = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1, "R2", "busy one cycle after start", busy, 1);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_accept();
        test_example();
        test_unaligned_min();
        test_zero_wait();
        test_start_mid_burst();
        test_start_in_turn();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule